// File: doc/BRIEF.md
# Bit Test and Modify Unit

This unit runs the four single-bit operations on a 16-bit word: test, test-and-set, test-and-reset and test-and-complement. The word is either a register operand presented on an input port or a word in memory reached through a simple request/acknowledge port. The bit position comes from a 16-bit register offset or from an 8-bit immediate.

In memory form with a register offset, the upper offset bits are taken as a signed word displacement. The tested bit may therefore lie in a word before or after the one at the base address. The carry output always reports the selected bit as it was before the operation. Modifying operations on memory run as a locked read followed by a write to the same address.

A caller pulses `start_i` while the unit is idle, or in the cycle in which `done_o` is high. It then waits for `done_o`, which marks the cycle in which `cf_o`, `result_o` and `reg_we_o` are valid. The unit produces no other status flags.

Top module: `bit_test_unit`

## Requirements
- R1: The bit index is bits 3..0 of the chosen offset source, which is `offset_i` when `imm_sel_i`=0 and `imm_i` when `imm_sel_i`=1. Bits 7..4 of the immediate have no effect on the index.
- R2: In memory form with a register offset, the access address is (`base_addr_i` + 2 × signed value of `offset_i[15:4]`) AND `addr_mask_i`.
- R3: In memory form with an immediate offset, the access address is `base_addr_i` AND `addr_mask_i`. `offset_i` has no effect on it.
- R4: `cf_o` equals the selected bit of the operand word before modification. It is valid while `done_o` is high and holds its value until the next operation updates it.
- R5: `op_i` encoding: 0 = test (word unchanged), 1 = set bit, 2 = clear bit, 3 = invert bit. When `done_o` is high, `result_o` is the word after the operation.
- R6: In register form, `done_o` rises in the cycle after start is accepted and no memory request is made. `reg_we_o` is high together with `done_o` for operations 1 to 3 and low for test.
- R7: A memory-form test makes exactly one read with `mem_lock_o` low and makes no write.
- R8: A memory-form modifying operation makes one read with `mem_lock_o` high, then one write of the modified word to the same address. `mem_lock_o` stays high through the write.
- R9: Once raised, `mem_req_o` is held with stable address, direction and write data until `mem_ack_i`.
- R10: `done_o` is a single-cycle pulse that follows the final acknowledge of a memory operation by one cycle. `busy_o` is high while a memory access is outstanding.
- R11: A start in the `done_o` cycle is accepted, which allows back-to-back operations. A start while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation |
| op_i | input | 2 | Operation code (R5) |
| mem_form_i | input | 1 | 1 = operand in memory, 0 = register operand |
| imm_sel_i | input | 1 | 1 = offset from immediate |
| reg_val_i | input | 16 | Register operand word |
| offset_i | input | 16 | Register bit offset |
| imm_i | input | 8 | Immediate bit offset |
| base_addr_i | input | 32 | Base byte address of the memory operand |
| addr_mask_i | input | 32 | Active address-size mask |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write request |
| mem_lock_o | output | 1 | Locked read-modify-write in progress |
| mem_addr_o | output | 32 | Word byte address |
| mem_wdata_o | output | 16 | Write data |
| mem_ack_i | input | 1 | Request acknowledge |
| mem_rdata_i | input | 16 | Read data, valid with acknowledge |
| busy_o | output | 1 | Memory access outstanding |
| done_o | output | 1 | Operation complete |
| cf_o | output | 1 | Prior value of the selected bit |
| result_o | output | 16 | Word after the operation |
| reg_we_o | output | 1 | Register write-back enable |

## Verification
Two things can fall in one cycle. A new start can arrive in the cycle in which `done_o` presents the previous result, and a start can arrive while the memory port is still waiting for its acknowledge. The bench provokes the first by driving start in the done cycle. It then checks that the first result is intact in that cycle and that the second result and a continued `done_o` appear in the next. It provokes the second by pulsing start with a different operation during a read that is held off by wait states. It then checks that the memory traffic and the result belong to the first operation alone. Random acknowledge latencies of zero to two cycles also place acknowledges in the very first cycle of a request.

// File: rtl/bt_pkg.sv
package bt_pkg;
  typedef enum logic [1:0] {
    BT_TEST  = 2'd0,
    BT_SET   = 2'd1,
    BT_CLEAR = 2'd2,
    BT_FLIP  = 2'd3
  } bt_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } bt_state_e;

  function automatic logic apply_bit(bt_op_e op, logic b);
    case (op)
      BT_SET:   return 1'b1;
      BT_CLEAR: return 1'b0;
      BT_FLIP:  return ~b;
      default:  return b;
    endcase
  endfunction
endpackage

// File: rtl/btm_addr_gen.sv
module btm_addr_gen #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              imm_sel_i,
  input  logic [DATA_W-1:0] offset_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] addr_mask_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int HI_W    = DATA_W - IDX_W;
  localparam int BYTE_SH = $clog2(DATA_W / 8);

  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] byte_off;

  // upper offset bits are a signed word displacement
  assign disp_ext = {{(ADDR_W-HI_W){offset_i[DATA_W-1]}}, offset_i[DATA_W-1:IDX_W]};
  assign byte_off = disp_ext << BYTE_SH;

  assign idx_o  = imm_sel_i ? imm_i[IDX_W-1:0] : offset_i[IDX_W-1:0];
  assign addr_o = (base_addr_i + (imm_sel_i ? '0 : byte_off)) & addr_mask_i;
endmodule

// File: rtl/btm_bit_alu.sv
module btm_bit_alu
  import bt_pkg::*;
#(
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  bt_op_e            op_i,
  output logic              cf_o,
  output logic [DATA_W-1:0] word_o
);
  assign cf_o = word_i[idx_i];

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    logic hit;
    assign hit       = (idx_i == IDX_W'(b));
    assign word_o[b] = hit ? apply_bit(op_i, word_i[b]) : word_i[b];
  end
endmodule

// File: rtl/btm_seq.sv
module btm_seq
  import bt_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic mem_form_i,
  input  logic modify_q_i,
  input  logic mem_ack_i,
  output logic accept_o,
  output logic rd_phase_o,
  output logic wr_phase_o,
  output logic done_o,
  output logic busy_o
);
  bt_state_e state_q, state_d;

  assign accept_o   = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
  assign rd_phase_o = (state_q == ST_READ);
  assign wr_phase_o = (state_q == ST_WRITE);
  assign done_o     = (state_q == ST_DONE);
  assign busy_o     = rd_phase_o || wr_phase_o;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (accept_o) state_d = mem_form_i ? ST_READ : ST_DONE;
        else          state_d = ST_IDLE;
      end
      ST_READ:  if (mem_ack_i) state_d = modify_q_i ? ST_WRITE : ST_DONE;
      ST_WRITE: if (mem_ack_i) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end
endmodule

// File: rtl/bit_test_unit.sv
module bit_test_unit
  import bt_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        op_i,
  input  logic              mem_form_i,
  input  logic              imm_sel_i,
  input  logic [DATA_W-1:0] reg_val_i,
  input  logic [DATA_W-1:0] offset_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [ADDR_W-1:0] addr_mask_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic              mem_lock_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              cf_o,
  output logic [DATA_W-1:0] result_o,
  output logic              reg_we_o
);
  localparam int IDX_W = $clog2(DATA_W);

  bt_op_e            op_q;
  logic              mem_q;
  logic [ADDR_W-1:0] addr_q;
  logic [IDX_W-1:0]  idx_q;
  logic              cf_q;
  logic [DATA_W-1:0] word_q;

  logic [ADDR_W-1:0] addr_new;
  logic [IDX_W-1:0]  idx_new;
  logic              accept, rd_phase, wr_phase, done;
  logic              modify_q;

  logic [DATA_W-1:0] alu_in, alu_out;
  logic [IDX_W-1:0]  alu_idx;
  bt_op_e            alu_op;
  logic              alu_cf;

  assign modify_q = (op_q != BT_TEST);

  btm_addr_gen #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_addr (
    .imm_sel_i   (imm_sel_i),
    .offset_i    (offset_i),
    .imm_i       (imm_i),
    .base_addr_i (base_addr_i),
    .addr_mask_i (addr_mask_i),
    .addr_o      (addr_new),
    .idx_o       (idx_new)
  );

  btm_seq u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .mem_form_i (mem_form_i),
    .modify_q_i (modify_q),
    .mem_ack_i  (mem_ack_i),
    .accept_o   (accept),
    .rd_phase_o (rd_phase),
    .wr_phase_o (wr_phase),
    .done_o     (done),
    .busy_o     (busy_o)
  );

  // one ALU shared by register operand (at accept) and read data (at read ack)
  assign alu_in  = rd_phase ? mem_rdata_i : reg_val_i;
  assign alu_idx = rd_phase ? idx_q : idx_new;
  assign alu_op  = rd_phase ? op_q : bt_op_e'(op_i);

  btm_bit_alu #(.DATA_W(DATA_W)) u_alu (
    .word_i (alu_in),
    .idx_i  (alu_idx),
    .op_i   (alu_op),
    .cf_o   (alu_cf),
    .word_o (alu_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= BT_TEST;
      mem_q  <= 1'b0;
      addr_q <= '0;
      idx_q  <= '0;
      cf_q   <= 1'b0;
      word_q <= '0;
    end else if (accept) begin
      op_q   <= bt_op_e'(op_i);
      mem_q  <= mem_form_i;
      addr_q <= addr_new;
      idx_q  <= idx_new;
      if (!mem_form_i) begin
        cf_q   <= alu_cf;
        word_q <= alu_out;
      end
    end else if (rd_phase && mem_ack_i) begin
      cf_q   <= alu_cf;
      word_q <= alu_out;
    end
  end

  assign mem_req_o   = rd_phase || wr_phase;
  assign mem_we_o    = wr_phase;
  assign mem_lock_o  = wr_phase || (rd_phase && modify_q);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = word_q;

  assign done_o   = done;
  assign cf_o     = cf_q;
  assign result_o = word_q;
  assign reg_we_o = done && !mem_q && modify_q;
endmodule

// File: rtl/bit_test_unit_chk.sv
module bit_test_unit_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic              mem_lock_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_ack_i,
  input logic              done_o,
  input logic              cf_o,
  input logic [DATA_W-1:0] result_o,
  input logic              reg_we_o
);
  assert_write_locked_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> mem_lock_o);

  assert_rmw_same_addr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_we_o && mem_lock_o && mem_ack_i
      |=> mem_req_o && mem_we_o && mem_lock_o && $stable(mem_addr_o));

  assert_req_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ack_i
      |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));

  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !done_o);

  assert_done_after_ack_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_ack_i && (mem_we_o || !mem_lock_o) |=> done_o);

  assert_regwe_no_mem_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> done_o && !mem_req_o);

  assert_done_no_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mem_req_o);

  assert_cf_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !mem_ack_i |=> $stable(cf_o) && $stable(result_o));
endmodule

bind bit_test_unit bit_test_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_lock_o  (mem_lock_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ack_i   (mem_ack_i),
  .done_o      (done_o),
  .cf_o        (cf_o),
  .result_o    (result_o),
  .reg_we_o    (reg_we_o)
);

// File: tb/bit_test_unit_test.sv
`timescale 1ns/1ps
module bit_test_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        memf = 1'b0;
  logic        isel = 1'b0;
  logic [15:0] regv = '0;
  logic [15:0] off = '0;
  logic [7:0]  imm = '0;
  logic [31:0] base = '0;
  logic [31:0] mask = '1;
  logic        req, we, lock, busy, done, cf, rwe;
  logic [31:0] maddr;
  logic [15:0] wdata, result;
  logic        ack = 1'b0;
  logic [15:0] rdata = '0;

  int tests = 0, fails = 0;
  int nrd, nwr, wait_cnt;
  logic [31:0] rd_addr, wr_addr;
  logic [15:0] wr_data, rd_word;
  logic rd_lock, wr_lock;

  always #10 clk = ~clk;

  bit_test_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .mem_form_i(memf),
    .imm_sel_i(isel), .reg_val_i(regv), .offset_i(off), .imm_i(imm),
    .base_addr_i(base), .addr_mask_i(mask), .mem_req_o(req), .mem_we_o(we),
    .mem_lock_o(lock), .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_ack_i(ack),
    .mem_rdata_i(rdata), .busy_o(busy), .done_o(done), .cf_o(cf),
    .result_o(result), .reg_we_o(rwe)
  );

  // memory responder: 0..2 wait states
  always @(negedge clk) begin
    if (ack) begin
      ack = 1'b0;
      wait_cnt = $urandom % 3;
    end else if (req) begin
      if (wait_cnt != 0) wait_cnt--;
      else begin
        ack = 1'b1;
        if (we) begin nwr++; wr_addr = maddr; wr_data = wdata; wr_lock = lock; end
        else begin nrd++; rd_addr = maddr; rd_lock = lock; rdata = rd_word; end
      end
    end
  end

  function automatic logic [15:0] exp_word(logic [15:0] w, logic [3:0] i, logic [1:0] o);
    case (o)
      2'd1: return w | (16'd1 << i);
      2'd2: return w & ~(16'd1 << i);
      2'd3: return w ^ (16'd1 << i);
      default: return w;
    endcase
  endfunction

  function automatic logic [31:0] exp_addr(logic [31:0] b, logic [15:0] o, logic s, logic [31:0] m);
    logic [31:0] d;
    d = {{20{o[15]}}, o[15:4]} << 1;
    return (b + (s ? 32'd0 : d)) & m;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // run one operation and check everything at the done cycle
  task automatic run_op(input logic [1:0] o, input logic mf, input logic s,
                        input logic [15:0] rv, input logic [15:0] of, input logic [7:0] im,
                        input logic [31:0] b, input logic [31:0] m, input logic [15:0] mw);
    logic [3:0] idx;
    logic [15:0] src;
    int loops;
    nrd = 0; nwr = 0; rd_word = mw;
    op = o; memf = mf; isel = s; regv = rv; off = of; imm = im; base = b; mask = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    loops = 0;
    while (!done && loops < 40) begin @(negedge clk); loops++; end
    idx = s ? im[3:0] : of[3:0];
    src = mf ? mw : rv;
    chk(done == 1'b1, "R10 done seen", {31'd0, done}, 32'd1);
    chk(cf == src[idx], "R1/R4 cf", {31'd0, cf}, {31'd0, src[idx]});
    chk(result == exp_word(src, idx, o), "R5 result", {16'd0, result}, {16'd0, exp_word(src, idx, o)});
    if (!mf) begin
      chk(loops == 0, "R6 reg done latency", loops, 0);
      chk(rwe == (o != 2'd0), "R6 reg_we", {31'd0, rwe}, {31'd0, o != 2'd0});
      chk(nrd == 0 && nwr == 0, "R6 no memory access", nrd + nwr, 0);
    end else begin
      chk(rwe == 1'b0, "R6 no reg_we in memory form", {31'd0, rwe}, 32'd0);
      chk(nrd == 1, "R7/R8 one read", nrd, 1);
      chk(rd_addr == exp_addr(b, of, s, m), s ? "R3 address" : "R2 address", rd_addr, exp_addr(b, of, s, m));
      if (o == 2'd0) begin
        chk(nwr == 0, "R7 no write", nwr, 0);
        chk(rd_lock == 1'b0, "R7 no lock", {31'd0, rd_lock}, 32'd0);
      end else begin
        chk(nwr == 1, "R8 one write", nwr, 1);
        chk(rd_lock && wr_lock, "R8 locked", {30'd0, rd_lock, wr_lock}, 32'd3);
        chk(wr_addr == rd_addr, "R8 same address", wr_addr, rd_addr);
        chk(wr_data == exp_word(mw, idx, o), "R8 write data", {16'd0, wr_data}, {16'd0, exp_word(mw, idx, o)});
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R10 done single pulse", {31'd0, done}, 32'd0);
    chk(cf == src[idx], "R4 cf held", {31'd0, cf}, {31'd0, src[idx]});
  endtask

  initial begin : watchdog
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [15:0] r1;
    wait_cnt = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!req && !done && !busy && !cf && !rwe, "R10 reset state", {27'd0, req, done, busy, cf, rwe}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_op(2'd1, 1'b0, 1'b1, 16'h0000, 16'hFFFF, 8'hF3, 32'h0, '1, 16'h0);      // R1 imm upper bits ignored
    run_op(2'd0, 1'b0, 1'b0, 16'h8000, 16'h00AF, 8'h00, 32'h0, '1, 16'h0);      // R1 bit 15 test
    run_op(2'd3, 1'b1, 1'b0, 16'h0, 16'hFFF5, 8'h0, 32'h0000_1000, '1, 16'h0020); // R2 negative displacement
    run_op(2'd2, 1'b1, 1'b0, 16'h0, 16'h0020, 8'h0, 32'h0001_FFFE, 32'h0000_FFFF, 16'hFFFF); // R2 mask wrap
    run_op(2'd1, 1'b1, 1'b1, 16'h0, 16'h7FF0, 8'hA9, 32'h0000_2000, '1, 16'h0000); // R3 offset ignored
    run_op(2'd0, 1'b1, 1'b0, 16'h0, 16'h8000, 8'h0, 32'h0000_4000, '1, 16'h0001);  // R7 test in memory

    // R11 back-to-back: start in done cycle
    op = 2'd1; memf = 1'b0; isel = 1'b1; imm = 8'h02; regv = 16'h00F0;
    start = 1'b1; @(negedge clk);
    op = 2'd3; imm = 8'h04; regv = 16'h00F0;
    r1 = result;
    chk(done && r1 == 16'h00F4, "R11 first result in done cycle", {16'd0, r1}, 32'h00F4);
    @(negedge clk);
    start = 1'b0;
    chk(done && result == 16'h00E0 && cf == 1'b1, "R11 second result follows", {16'd0, result}, 32'h00E0);
    @(negedge clk);

    // R11 start while busy ignored
    nrd = 0; nwr = 0; rd_word = 16'h1234; wait_cnt = 2;
    op = 2'd1; memf = 1'b1; isel = 1'b1; imm = 8'h00; base = 32'h100; mask = '1;
    start = 1'b1; @(negedge clk);
    op = 2'd2; memf = 1'b0; imm = 8'h04; regv = 16'hFFFF;
    chk(busy == 1'b1, "R10 busy during access", {31'd0, busy}, 32'd1);
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 20 && !done; k++) @(negedge clk);
    chk(result == 16'h1235 && nwr == 1 && wr_data == 16'h1235, "R11 busy start ignored", {16'd0, result}, 32'h1235);
    @(negedge clk);

    // constrained random
    for (int n = 0; n < 250; n++) begin
      run_op(2'($urandom), 1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
             8'($urandom), $urandom, ($urandom % 2) ? 32'hFFFF_FFFF : 32'h0000_FFFF, 16'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule